// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block holds wall-clock time and date as packed BCD registers: seconds, minutes, hours, weekday, day of month, month with a century flag, and a two-digit year. An input pulse stream from a slow oscillator is divided by a parameterized prescaler into a one-second tick, and each tick advances the seconds with carries rippling through the wider fields. Day-of-month limits follow the month length, and February takes 29 days in years divisible by four.

The hour register runs either in 24-hour form (00 to 23) or in 12-hour form with a PM flag in bit 5, where midnight reads as 12 AM and noon as 12 PM. A host port writes any field, selects the hour format and clears two fault flags. The flags record an oscillator stop and a low supply voltage, and each is set by an input strobe. The read port is a combinational multiplexer over the same address map.

Top module: `bcd_clock_cal`

Address map (4-bit address): 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 mode control, 8 status. Unused addresses read 0x00.

## Requirements
- R1: After a synchronous active-low reset, the registers read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x00, mode control 0x20 (24-hour) and status 0x10 (oscillator-stop flag set).
- R2: Seconds advance by one on every PRESCALE-th `osc_pulse`, never more than once per tick. A host write to any of addresses 0 to 6 clears the prescaler, so the next advance needs a full PRESCALE pulses.
- R3: Seconds roll from 0x59 to 0x00 and advance the minutes, and minutes roll from 0x59 to 0x00 and advance the hours.
- R4: In 24-hour mode the hour steps from 0x23 to 0x00 and advances the day.
- R5: In 12-hour mode (hour bit 5 = PM, low five bits = BCD 01..12), 11 AM steps to 12 PM (0x32), 12 steps to 01 with PM unchanged, and 11 PM (0x31) steps to 12 AM (0x12) and advances the day.
- R6: The weekday (bits 2:0) steps 0 to 6 and wraps to 0 each time the day advances. A weekday of 6 or more wraps to 0.
- R7: After the last day of the month the day returns to 0x01 and the month advances. Months 04, 06, 09 and 11 have 30 days, and the other months except February have 31.
- R8: February ends on day 0x29 when the BCD year is divisible by four (year 00 included), and on day 0x28 otherwise.
- R9: Month 0x12 rolls to 0x01 and advances the year. Year 0x99 rolls to 0x00 and sets the century flag (month bit 7), which stays set until the month register is written.
- R10: Host writes keep only the field bits: seconds and minutes bits 6:0, hours bits 5:0, weekday bits 2:0, day bits 5:0, month bits 7 and 4:0, year bits 7:0, mode control bit 5. All other bits read 0.
- R11: Status bit 4 is set by `osc_stop_evt` and bit 6 by `low_volt_evt`. A status write clears each flag whose data bit is 0 and leaves it unchanged where the data bit is 1. An event in the same cycle wins over the clear.
- R12: Mode control bit 5 set selects 24-hour mode and clear selects 12-hour mode. A change of mode does not convert the stored hour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_pulse | input | 1 | One-cycle strobe per oscillator period, input to the prescaler |
| osc_stop_evt | input | 1 | Strobe that sets the oscillator-stop flag |
| low_volt_evt | input | 1 | Strobe that sets the low-voltage flag |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |

## Verification
On every cycle, assertions check the following. Seconds stay unchanged when there is neither a tick nor a seconds write. The tick never fires on two cycles in a row. The fault flags are set the cycle after their strobes. The century flag persists. The hour steps 23 to 00 in 24-hour mode and 11 AM to 12 PM in 12-hour mode. The month-length table, the leap-year rule, the year and century rollover, the field masking and the flag clear semantics depend on particular register contents, so only the directed scenarios show them.

// File: rtl/cal_pkg.sv
// Package cal_pkg: shared address map, bit positions and BCD helper for the
// calendar counter. Assumes all counted fields hold valid packed BCD.
package cal_pkg;

    typedef enum logic [3:0] {
        A_SEC  = 4'd0,
        A_MIN  = 4'd1,
        A_HOUR = 4'd2,
        A_WDAY = 4'd3,
        A_DAY  = 4'd4,
        A_MON  = 4'd5,
        A_YEAR = 4'd6,
        A_MODE = 4'd7,
        A_STAT = 4'd8
    } cal_addr_e;

    localparam int MODE24_BIT = 5;
    localparam int PM_BIT     = 5;
    localparam int CENT_BIT   = 7;
    localparam int OSC_BIT    = 4;
    localparam int LOWV_BIT   = 6;

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Module cal_prescaler: divides the oscillator pulse stream by DIV into a
// one-cycle seconds tick. A restart request clears the count and blocks
// the tick in that cycle. Assumes DIV >= 1.
module cal_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Tick when the last pulse of a period arrives and no restart is pending.
    assign tick = pulse && !restart && (cnt_q == LAST);

    // Pulse counter: cleared by reset, restart or a completed period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else if (pulse)
            cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2: the tick never fires on two consecutive cycles.
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/cal_hour_step.sv
// Module cal_hour_step: next hour value for one hour advance in either
// 24-hour or 12-hour (PM flag in bit 5) format, plus the day carry.
// Assumes the stored hour is valid for the selected format.
module cal_hour_step (
    input  logic [5:0] hour_in,
    input  logic       mode24,
    output logic [5:0] hour_out,
    output logic       day_carry
);
    import cal_pkg::*;

    logic [7:0] inc24;
    logic [7:0] inc12;

    // Combinational step: 24-hour wrap at 23, 12-hour 11->12 flips PM.
    always_comb begin
        inc24     = bcd_inc({2'b00, hour_in});
        inc12     = bcd_inc({3'b000, hour_in[4:0]});
        hour_out  = '0;
        day_carry = 1'b0;
        if (mode24) begin
            if (hour_in >= 6'h23) begin
                hour_out  = 6'h00;
                day_carry = 1'b1;
            end else begin
                hour_out = inc24[5:0];
            end
        end else begin
            if (hour_in[4:0] == 5'h11) begin
                hour_out  = {~hour_in[PM_BIT], 5'h12};
                day_carry = hour_in[PM_BIT];
            end else if (hour_in[4:0] >= 5'h12) begin
                hour_out = {hour_in[PM_BIT], 5'h01};
            end else begin
                hour_out = {hour_in[PM_BIT], inc12[4:0]};
            end
        end
    end

endmodule

// File: rtl/cal_month_len.sv
// Module cal_month_len: last BCD day of a month, with February extended to
// 29 in years whose two BCD digits are divisible by four.
// Assumes month and year are valid BCD.
module cal_month_len (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [5:0] last_day
);
    logic leap;

    // A tens digit that is even pairs with units 0/4/8, odd with 2/6.
    always_comb begin
        if (!year[4])
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        else
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    end

    // Month length lookup in BCD.
    always_comb begin
        case (month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end

endmodule

// File: rtl/bcd_clock_cal.sv
// Module bcd_clock_cal: BCD time-of-day and calendar counter with a host
// write/read port, 12/24-hour format and two sticky fault flags.
// Assumes the host loads valid BCD; invalid values wrap at the next step.
module bcd_clock_cal #(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_pulse,
    input  logic       osc_stop_evt,
    input  logic       low_volt_evt,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data
);
    import cal_pkg::*;

    logic [6:0] sec_q, min_q;
    logic [5:0] hour_q, day_q;
    logic [2:0] wday_q;
    logic [4:0] mon_q;
    logic       cent_q, mode24_q, osc_flag_q, lowv_flag_q;
    logic [7:0] year_q;

    logic       wr_time, sec_tick;
    logic       sec_wrap, min_wrap, day_wrap, mon_wrap, year_wrap;
    logic       min_step, hour_step, day_step, mon_step, year_step;
    logic       hr_carry;
    logic [5:0] hour_nxt, last_day;
    logic [7:0] sec_inc, min_inc, day_inc, mon_inc, year_inc;

    assign wr_time = wr_en && (wr_addr <= A_YEAR);

    cal_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (osc_pulse),
        .restart (wr_time),
        .tick    (sec_tick)
    );

    cal_hour_step u_hour (
        .hour_in   (hour_q),
        .mode24    (mode24_q),
        .hour_out  (hour_nxt),
        .day_carry (hr_carry)
    );

    cal_month_len u_mlen (
        .month    (mon_q),
        .year     (year_q),
        .last_day (last_day)
    );

    // Carry chain: each field steps when all lower fields wrap on a tick.
    always_comb begin
        sec_inc   = bcd_inc({1'b0, sec_q});
        min_inc   = bcd_inc({1'b0, min_q});
        day_inc   = bcd_inc({2'b00, day_q});
        mon_inc   = bcd_inc({3'b000, mon_q});
        year_inc  = bcd_inc(year_q);
        sec_wrap  = sec_q >= 7'h59;
        min_wrap  = min_q >= 7'h59;
        day_wrap  = day_q >= last_day;
        mon_wrap  = mon_q >= 5'h12;
        year_wrap = year_q >= 8'h99;
        min_step  = sec_tick && sec_wrap;
        hour_step = min_step && min_wrap;
        day_step  = hour_step && hr_carry;
        mon_step  = day_step && day_wrap;
        year_step = mon_step && mon_wrap;
    end

    // Time fields: host write first, otherwise the carry chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
            wday_q <= '0;
            day_q  <= 6'h01;
            mon_q  <= 5'h01;
            cent_q <= 1'b0;
            year_q <= '0;
        end else if (wr_time) begin
            case (wr_addr)
                A_SEC:  sec_q  <= wr_data[6:0];
                A_MIN:  min_q  <= wr_data[6:0];
                A_HOUR: hour_q <= wr_data[5:0];
                A_WDAY: wday_q <= wr_data[2:0];
                A_DAY:  day_q  <= wr_data[5:0];
                A_MON: begin
                    mon_q  <= wr_data[4:0];
                    cent_q <= wr_data[CENT_BIT];
                end
                default: year_q <= wr_data;
            endcase
        end else if (sec_tick) begin
            sec_q <= sec_wrap ? 7'h00 : sec_inc[6:0];
            if (min_step)  min_q  <= min_wrap ? 7'h00 : min_inc[6:0];
            if (hour_step) hour_q <= hour_nxt;
            if (day_step) begin
                wday_q <= (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
                day_q  <= day_wrap ? 6'h01 : day_inc[5:0];
            end
            if (mon_step)  mon_q  <= mon_wrap ? 5'h01 : mon_inc[4:0];
            if (year_step) begin
                year_q <= year_wrap ? 8'h00 : year_inc;
                if (year_wrap) cent_q <= 1'b1;
            end
        end
    end

    // Hour format select, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode24_q <= 1'b1;
        else if (wr_en && wr_addr == A_MODE)
            mode24_q <= wr_data[MODE24_BIT];
    end

    // Fault flags: strobes set, host clears where the data bit is 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_flag_q  <= 1'b1;
            lowv_flag_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_STAT) begin
                osc_flag_q  <= (osc_flag_q & wr_data[OSC_BIT]) | osc_stop_evt;
                lowv_flag_q <= (lowv_flag_q & wr_data[LOWV_BIT]) | low_volt_evt;
            end else begin
                osc_flag_q  <= osc_flag_q | osc_stop_evt;
                lowv_flag_q <= lowv_flag_q | low_volt_evt;
            end
        end
    end

    // Read multiplexer over the host address map.
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = {1'b0, sec_q};
            A_MIN:   rd_data = {1'b0, min_q};
            A_HOUR:  rd_data = {2'b00, hour_q};
            A_WDAY:  rd_data = {5'b0, wday_q};
            A_DAY:   rd_data = {2'b00, day_q};
            A_MON:   rd_data = {cent_q, 2'b00, mon_q};
            A_YEAR:  rd_data = year_q;
            A_MODE:  rd_data = {2'b00, mode24_q, 5'b0};
            A_STAT:  rd_data = {1'b0, lowv_flag_q, 1'b0, osc_flag_q, 4'b0};
            default: rd_data = 8'h00;
        endcase
    end

    // R2: seconds hold without a tick or a seconds write.
    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !(wr_en && wr_addr == A_SEC)) |=> $stable(sec_q));

    // R4: 23:59:59 in 24-hour mode steps to hour 00.
    p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && mode24_q && hour_q == 6'h23 && min_q == 7'h59 && sec_q == 7'h59)
        |=> (hour_q == 6'h00));

    // R5: 11:59:59 AM in 12-hour mode steps to 12 PM.
    p_noon_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !mode24_q && hour_q == 6'h11 && min_q == 7'h59 && sec_q == 7'h59)
        |=> (hour_q == 6'h32));

    // R9: century flag persists until the month register is written.
    p_cent_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cent_q && !(wr_en && wr_addr == A_MON)) |=> cent_q);

    // R11: each fault strobe shows up in its flag the next cycle.
    p_osc_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_evt |=> osc_flag_q);
    p_lowv_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt_evt |=> lowv_flag_q);

endmodule

// File: tb/bcd_clock_cal_tb.sv
module bcd_clock_cal_tb;
    localparam int PS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_pulse = 1'b0;
    logic       osc_stop_evt = 1'b0;
    logic       low_volt_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_clock_cal #(.PRESCALE(PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_pulse(osc_pulse),
        .osc_stop_evt(osc_stop_evt), .low_volt_evt(low_volt_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #0.5;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_pulse = 1'b1;
            @(negedge clk); osc_pulse = 1'b0;
        end
    endtask

    // Load hh:59:59 with given date; the last write realigns the prescaler.
    task automatic load(input logic [7:0] hr, input logic [7:0] wd, input logic [7:0] dy,
                        input logic [7:0] mo, input logic [7:0] yr);
        wr(4'd2, hr); wr(4'd3, wd); wr(4'd4, dy); wr(4'd5, mo); wr(4'd6, yr);
        wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    endtask

    task automatic t_reset;
        chk(0, 8'h00, "R1 sec"); chk(1, 8'h00, "R1 min"); chk(2, 8'h00, "R1 hour");
        chk(3, 8'h00, "R1 wday"); chk(4, 8'h01, "R1 day"); chk(5, 8'h01, "R1 month");
        chk(6, 8'h00, "R1 year"); chk(7, 8'h20, "R1 mode"); chk(8, 8'h10, "R1 status");
    endtask

    task automatic t_prescale;
        wr(0, 8'h10);
        pulses(PS - 1); chk(0, 8'h10, "R2 before period");
        pulses(1);      chk(0, 8'h11, "R2 after period");
        pulses(2); wr(1, 8'h05);
        pulses(PS - 1); chk(0, 8'h11, "R2 restart holds");
        pulses(1);      chk(0, 8'h12, "R2 restart then tick");
    endtask

    task automatic t_sec_min;
        load(8'h05, 8'h01, 8'h10, 8'h03, 8'h20);
        pulses(PS);
        chk(0, 8'h00, "R3 sec wrap"); chk(1, 8'h00, "R3 min wrap"); chk(2, 8'h06, "R3 hour carry");
    endtask

    task automatic t_hour24;
        load(8'h23, 8'h02, 8'h10, 8'h03, 8'h20);
        pulses(PS);
        chk(2, 8'h00, "R4 hour 23->00"); chk(4, 8'h11, "R4 day advance"); chk(3, 8'h03, "R6 wday step");
    endtask

    task automatic t_hour12;
        wr(7, 8'hFF); chk(7, 8'h20, "R12 mode mask");
        wr(7, 8'h00); chk(7, 8'h00, "R12 12h select");
        load(8'h11, 8'h02, 8'h05, 8'h03, 8'h20);
        pulses(PS);
        chk(2, 8'h32, "R5 11AM->12PM"); chk(4, 8'h05, "R5 noon keeps day");
        wr(1, 8'h59); wr(0, 8'h59); pulses(PS);
        chk(2, 8'h21, "R5 12PM->1PM");
        load(8'h31, 8'h02, 8'h05, 8'h03, 8'h20);
        pulses(PS);
        chk(2, 8'h12, "R5 11PM->12AM"); chk(4, 8'h06, "R5 midnight day");
        wr(7, 8'h20);
        chk(2, 8'h12, "R12 mode change keeps hour");
    endtask

    task automatic t_wday;
        load(8'h23, 8'h06, 8'h10, 8'h03, 8'h20);
        pulses(PS);
        chk(3, 8'h00, "R6 wday wrap");
    endtask

    task automatic t_month;
        load(8'h23, 8'h01, 8'h30, 8'h04, 8'h20);
        pulses(PS);
        chk(4, 8'h01, "R7 April 30 day"); chk(5, 8'h05, "R7 April 30 month");
        load(8'h23, 8'h01, 8'h30, 8'h01, 8'h20);
        pulses(PS);
        chk(4, 8'h31, "R7 Jan 30->31");
        load(8'h23, 8'h01, 8'h31, 8'h01, 8'h20);
        pulses(PS);
        chk(4, 8'h01, "R7 Jan 31 day"); chk(5, 8'h02, "R7 Jan 31 month");
    endtask

    task automatic t_leap;
        load(8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        pulses(PS); chk(5, 8'h03, "R8 Feb 28 common");
        load(8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        pulses(PS); chk(4, 8'h29, "R8 Feb 29 leap");
        wr(1, 8'h59); wr(0, 8'h59); wr(2, 8'h23); pulses(PS);
        chk(5, 8'h03, "R8 Feb 29 rolls");
        load(8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        pulses(PS); chk(4, 8'h29, "R8 year 00 leap");
    endtask

    task automatic t_year;
        load(8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
        pulses(PS);
        chk(6, 8'h00, "R9 year 99->00"); chk(5, 8'h81, "R9 century set");
        load(8'h23, 8'h01, 8'h31, 8'h92, 8'h45);
        pulses(PS);
        chk(6, 8'h46, "R9 year step"); chk(5, 8'h81, "R9 century kept");
    endtask

    task automatic t_mask;
        wr(0, 8'hFF); chk(0, 8'h7F, "R10 sec mask");
        wr(2, 8'hFF); chk(2, 8'h3F, "R10 hour mask");
        wr(3, 8'hFF); chk(3, 8'h07, "R10 wday mask");
        wr(5, 8'hFF); chk(5, 8'h9F, "R10 month mask");
        wr(4, 8'hFF); chk(4, 8'h3F, "R10 day mask");
    endtask

    task automatic t_flags;
        wr(8, 8'h00); chk(8, 8'h00, "R11 clear both");
        @(negedge clk); low_volt_evt = 1'b1; @(negedge clk); low_volt_evt = 1'b0;
        chk(8, 8'h40, "R11 low volt set");
        @(negedge clk); osc_stop_evt = 1'b1; @(negedge clk); osc_stop_evt = 1'b0;
        chk(8, 8'h50, "R11 osc stop set");
        wr(8, 8'h40); chk(8, 8'h40, "R11 selective clear");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h00; osc_stop_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; osc_stop_evt = 1'b0;
        chk(8, 8'h10, "R11 event beats clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_sec_min();
        t_hour24();
        t_hour12();
        t_wday();
        t_month();
        t_leap();
        t_year();
        t_mask();
        t_flags();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule